// File: doc/BRIEF.md
# Congestion-Driven Warp Limit Controller

This block sets the number of warps that a throughput core may keep in flight. Its aim is to limit the pressure that core puts on a memory system it shares with latency-sensitive cores. Each cycle it can receive three stall events:

- a request held back because a memory controller queue was full;
- a request held back because the reply network was full;
- a cycle in which the core issued no warp.

It counts each event over an epoch whose length is programmable. At the last cycle of every epoch it sorts the two memory-side counts into three congestion levels and moves a saturating warp limit up one, down one, or leaves it where it is.

Two policies are available. The congestion-only policy looks at the memory-side levels alone. The balanced policy takes the same decision and then overrides it with a raise when the issue-stall count has climbed by more than a programmable margin compared with the previous epoch. A larger margin makes the override rarer, which favours the latency-sensitive cores. The epoch length, all four thresholds, the margin and the maximum limit are plain inputs, so a register bank elsewhere can drive them.

Top module: `warp_limit_ctrl`

## Requirements
- R1: While `rst_n` is low on a clock edge (synchronous reset), `warp_limit` loads the effective maximum and `limit_upd` is 0. The effective maximum is `max_warps`, or 1 when `max_warps` is 0.
- R2: An epoch lasts `epoch_len` cycles, or 1 cycle when `epoch_len` is 0. The first epoch starts with the first edge after reset is released. `limit_upd` is high for exactly one cycle, the cycle after the last edge of each epoch, and is low at every other time.
- R3: Each memory-side count (memory controller, reply network) is graded separately:
  - low when it is below its low threshold;
  - high when it is at or above its high threshold;
  - medium otherwise.
- R4: If at least one of the two grades is high and no override applies, the limit drops by one. It never falls below 1.
- R5: If both grades are low, the limit rises by one. It never exceeds the effective maximum.
- R6: For any other combination of grades with no override, the limit keeps its value.
- R7: After each decision the limit is clamped into the range 1 to the effective maximum. A lowered `max_warps` therefore takes effect at the next epoch end, and not before.
- R8: When `mode_bal` is 1, the override applies if this epoch's issue-stall count is strictly greater than the previous epoch's count plus `k_th`. When it applies, it replaces the congestion decision with a one-step raise.
- R9: When `mode_bal` is 0, issue-stall events have no effect on the limit.
- R10: Every event count covers the events of its own epoch only, including the epoch's last cycle. A count holds at its all-ones value instead of wrapping.
- R11: The previous-epoch issue-stall count is 0 after reset. At every epoch end it takes the count of the epoch that just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bal | input | 1 | 1 selects the balanced policy, 0 the congestion-only policy |
| epoch_len | input | EPOCH_W | Epoch length in cycles (0 is taken as 1) |
| mc_stall | input | 1 | Memory controller full stall event this cycle |
| net_stall | input | 1 | Reply network full stall event this cycle |
| issue_stall | input | 1 | The core issued no warp this cycle |
| mc_lo_th | input | CNT_W | Low threshold for the memory controller count |
| mc_hi_th | input | CNT_W | High threshold for the memory controller count |
| net_lo_th | input | CNT_W | Low threshold for the reply network count |
| net_hi_th | input | CNT_W | High threshold for the reply network count |
| k_th | input | CNT_W | Issue-stall growth margin for the override |
| max_warps | input | WARP_W | Configured maximum warp limit |
| warp_limit | output | WARP_W | Current active warp limit |
| limit_upd | output | 1 | One-cycle pulse after each epoch decision |

## Verification
Directed epochs place each count exactly one below, at, and above its thresholds, so an off-by-one grading is caught. They also load each metric alone, so the memory controller path and the network path are tested separately.

Issue-stall patterns are chosen so that the growth lands exactly at the margin and one past it. The same pattern is then run under both policies, which separates the override from the plain congestion rule. Other epochs cover the ceiling, the floor, a lowered maximum, a one-cycle epoch, a reset that must clear the saved issue-stall count, and an epoch longer than the counter range.

Many random epochs with random lengths, event densities, thresholds and policies then exercise mixed grade combinations against a model of the rules.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MED  = 2'd1,
        LVL_HIGH = 2'd2
    } cong_lvl_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_RAISE = 2'd1,
        ACT_LOWER = 2'd2
    } limit_act_e;

endpackage

// File: rtl/wlc_sat_ctr.sv
module wlc_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q, cnt_d, incl;

    always_comb begin
        incl  = (ev && (cnt_q != '1)) ? cnt_q + 1'b1 : cnt_q;
        cnt_d = clr ? '0 : incl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = incl;

    // R10: the count stays at all-ones while not cleared
    a_r10_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '1) && !clr) |=> (cnt_q == '1));

    // R10: without a clear the count never decreases
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/wlc_classify.sv
module wlc_classify
    import wlc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo_th,
    input  logic [W-1:0] hi_th,
    output cong_lvl_e    lvl
);
    always_comb begin
        if (val >= hi_th)     lvl = LVL_HIGH;
        else if (val < lo_th) lvl = LVL_LOW;
        else                  lvl = LVL_MED;
    end

    // R3: a high grade implies the value reached the high threshold
    always_comb begin
        a_r3_high_grade: assert ((lvl != LVL_HIGH) || (val >= hi_th));
    end

endmodule

// File: rtl/warp_limit_ctrl.sv
module warp_limit_ctrl
    import wlc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int EPOCH_W = 16,
    parameter int WARP_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_bal,
    input  logic [EPOCH_W-1:0] epoch_len,
    input  logic               mc_stall,
    input  logic               net_stall,
    input  logic               issue_stall,
    input  logic [CNT_W-1:0]   mc_lo_th,
    input  logic [CNT_W-1:0]   mc_hi_th,
    input  logic [CNT_W-1:0]   net_lo_th,
    input  logic [CNT_W-1:0]   net_hi_th,
    input  logic [CNT_W-1:0]   k_th,
    input  logic [WARP_W-1:0]  max_warps,
    output logic [WARP_W-1:0]  warp_limit,
    output logic               limit_upd
);
    localparam int NUM_EV  = 3;
    localparam int NUM_MEM = 2;
    localparam int IDX_ISS = 2;

    typedef struct packed {
        logic [EPOCH_W-1:0] ep;
        logic [WARP_W-1:0]  lim;
        logic [CNT_W-1:0]   prev;
        logic               upd;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_EV-1:0] ev_vec;
    logic [CNT_W-1:0]  cnt    [NUM_EV];
    logic [CNT_W-1:0]  lo_arr [NUM_MEM];
    logic [CNT_W-1:0]  hi_arr [NUM_MEM];
    cong_lvl_e         lvl    [NUM_MEM];

    logic [EPOCH_W-1:0] len_m1;
    logic               ep_end;
    logic [WARP_W-1:0]  max_eff;
    logic               any_high, both_low, ovr;
    logic [CNT_W:0]     grow_lim;
    limit_act_e         act;
    logic [WARP_W-1:0]  stepped, new_lim;

    assign ev_vec    = {issue_stall, net_stall, mc_stall};
    assign lo_arr[0] = mc_lo_th;
    assign hi_arr[0] = mc_hi_th;
    assign lo_arr[1] = net_lo_th;
    assign hi_arr[1] = net_hi_th;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ctr
        wlc_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev_vec[g]),
            .clr   (ep_end),
            .cnt_o (cnt[g])
        );
    end

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_cls
        wlc_classify #(.W(CNT_W)) u_cls (
            .val   (cnt[g]),
            .lo_th (lo_arr[g]),
            .hi_th (hi_arr[g]),
            .lvl   (lvl[g])
        );
    end

    always_comb begin
        len_m1   = (epoch_len == '0) ? '0 : epoch_len - 1'b1;
        ep_end   = (st_q.ep >= len_m1);
        max_eff  = (max_warps == '0) ? WARP_W'(1) : max_warps;
        any_high = (lvl[0] == LVL_HIGH) || (lvl[1] == LVL_HIGH);
        both_low = (lvl[0] == LVL_LOW) && (lvl[1] == LVL_LOW);
        grow_lim = {1'b0, st_q.prev} + {1'b0, k_th};
        ovr      = mode_bal && ({1'b0, cnt[IDX_ISS]} > grow_lim);

        if (ovr)           act = ACT_RAISE;
        else if (any_high) act = ACT_LOWER;
        else if (both_low) act = ACT_RAISE;
        else               act = ACT_HOLD;

        unique case (act)
            ACT_RAISE: stepped = (st_q.lim < max_eff) ? st_q.lim + 1'b1 : max_eff;
            ACT_LOWER: stepped = (st_q.lim > WARP_W'(1)) ? st_q.lim - 1'b1 : WARP_W'(1);
            default:   stepped = st_q.lim;
        endcase

        if (stepped > max_eff)      new_lim = max_eff;
        else if (stepped == '0)     new_lim = WARP_W'(1);
        else                        new_lim = stepped;

        st_d     = st_q;
        st_d.upd = 1'b0;
        if (ep_end) begin
            st_d.ep   = '0;
            st_d.lim  = new_lim;
            st_d.prev = cnt[IDX_ISS];
            st_d.upd  = 1'b1;
        end else begin
            st_d.ep = st_q.ep + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ep   <= '0;
            st_q.lim  <= (max_warps == '0) ? WARP_W'(1) : max_warps;
            st_q.prev <= '0;
            st_q.upd  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign warp_limit = st_q.lim;
    assign limit_upd  = st_q.upd;

    // R7: the limit never reaches zero once out of reset
    a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        warp_limit != '0);

    // R2: outside an epoch end the limit does not move
    a_r2_hold_mid_epoch: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_end |=> $stable(warp_limit));

    // R4: a high grade without override never raises the limit
    a_r4_high_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_end && any_high && !ovr) |=> (warp_limit <= $past(st_q.lim)));

    // R5: two low grades never lower a limit that was within range
    a_r5_low_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_end && both_low && (st_q.lim <= max_eff)) |=> (warp_limit >= $past(st_q.lim)));

    // R8: the override raises by exactly one step when below the maximum
    a_r8_override_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_end && ovr && (st_q.lim < max_eff)) |=>
        (warp_limit == WARP_W'($past(st_q.lim) + 1'b1)));

endmodule

// File: tb/sim_warp_limit_ctrl.sv
module sim_warp_limit_ctrl;
    localparam int CW = 8;
    localparam int EW = 10;
    localparam int WW = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_bal = 1'b0;
    logic [EW-1:0] epoch_len = 10'd16;
    logic          mc_stall = 1'b0, net_stall = 1'b0, issue_stall = 1'b0;
    logic [CW-1:0] mc_lo_th = 8'd4, mc_hi_th = 8'd8;
    logic [CW-1:0] net_lo_th = 8'd4, net_hi_th = 8'd8;
    logic [CW-1:0] k_th = 8'd5;
    logic [WW-1:0] max_warps = 6'd24;
    logic [WW-1:0] warp_limit;
    logic          limit_upd;

    int n_chk = 0;
    int n_err = 0;
    int exp_lim = 0;
    int exp_prev = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    warp_limit_ctrl #(.CNT_W(CW), .EPOCH_W(EW), .WARP_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_bal(mode_bal), .epoch_len(epoch_len),
        .mc_stall(mc_stall), .net_stall(net_stall), .issue_stall(issue_stall),
        .mc_lo_th(mc_lo_th), .mc_hi_th(mc_hi_th),
        .net_lo_th(net_lo_th), .net_hi_th(net_hi_th),
        .k_th(k_th), .max_warps(max_warps),
        .warp_limit(warp_limit), .limit_upd(limit_upd)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int max_e();
        return (max_warps == 0) ? 1 : int'(max_warps);
    endfunction

    // 0 low, 1 medium, 2 high
    function automatic int grade(input int v, input int lo, input int hi);
        if (v >= hi) return 2;
        if (v < lo)  return 0;
        return 1;
    endfunction

    function automatic int model(input int lim, input int sm, input int sn, input int si);
        int gm, gn, st, mx;
        bit ovr;
        mx  = max_e();
        gm  = grade(sm, int'(mc_lo_th), int'(mc_hi_th));
        gn  = grade(sn, int'(net_lo_th), int'(net_hi_th));
        ovr = mode_bal && (si > exp_prev + int'(k_th));
        if (ovr || (gm == 0 && gn == 0) && !(gm == 2 || gn == 2))
            st = (lim < mx) ? lim + 1 : mx;
        else if (gm == 2 || gn == 2)
            st = (lim > 1) ? lim - 1 : 1;
        else
            st = lim;
        if (st > mx) st = mx;
        if (st < 1)  st = 1;
        return st;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(int'(warp_limit) == max_e(), "R1 reset limit", int'(warp_limit), max_e());
        chk(limit_upd == 1'b0, "R1 reset pulse", int'(limit_upd), 0);
        rst_n    = 1'b1;
        exp_lim  = max_e();
        exp_prev = 0;
    endtask

    // cm/cn/ci: event counts in the first cycles, or percentages when rnd is set
    task automatic run_epoch(input int n, input int cm, input int cn, input int ci,
                             input bit rnd, input string tag);
        int eff, sm, sn, si, nxt;
        bit mid_bad;
        epoch_len = EW'(n);
        eff = (n == 0) ? 1 : n;
        sm = 0; sn = 0; si = 0; mid_bad = 1'b0;
        for (int i = 0; i < eff; i++) begin
            bit em, en, ei;
            if (rnd) begin
                em = int'($urandom % 100) < cm;
                en = int'($urandom % 100) < cn;
                ei = int'($urandom % 100) < ci;
            end else begin
                em = i < cm; en = i < cn; ei = i < ci;
            end
            mc_stall = em; net_stall = en; issue_stall = ei;
            if (em && sm < CMAX) sm++;
            if (en && sn < CMAX) sn++;
            if (ei && si < CMAX) si++;
            @(negedge clk);
            if (i < eff - 1 && limit_upd) mid_bad = 1'b1;
        end
        mc_stall = 1'b0; net_stall = 1'b0; issue_stall = 1'b0;
        nxt = model(exp_lim, sm, sn, si);
        chk(!mid_bad, {"R2 no pulse inside epoch ", tag}, int'(mid_bad), 0);
        chk(limit_upd == 1'b1, {"R2 pulse at epoch end ", tag}, int'(limit_upd), 1);
        chk(int'(warp_limit) == nxt, tag, int'(warp_limit), nxt);
        exp_lim  = nxt;
        exp_prev = si;
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        run_epoch(16, 0, 0, 0, 0, "R5 raise saturates at maximum");
        run_epoch(16, 16, 0, 0, 0, "R4 mc high lowers");
        run_epoch(16, 8, 0, 0, 0, "R3 count at high threshold is high");
        run_epoch(16, 4, 0, 0, 0, "R3 count at low threshold is medium R6 hold");
        run_epoch(16, 3, 3, 0, 0, "R3 below low threshold R5 raise");
        run_epoch(16, 0, 8, 0, 0, "R4 network high lowers");
        run_epoch(16, 0, 5, 0, 0, "R6 network medium holds");
        run_epoch(0, 0, 0, 0, 0, "R2 zero length epoch raises");
        run_epoch(1, 0, 0, 0, 0, "R2 one cycle epoch");

        max_warps = 6'd3;
        run_epoch(8, 0, 0, 0, 0, "R7 lowered maximum clamps");
        run_epoch(16, 16, 0, 0, 0, "R4 lower from 3");
        run_epoch(16, 16, 0, 0, 0, "R4 lower to 1");
        run_epoch(16, 16, 16, 0, 0, "R4 floor at 1");

        mode_bal = 1'b1;
        run_epoch(16, 16, 0, 6, 0, "R8 override beats high grade");
        run_epoch(16, 16, 0, 11, 0, "R8 growth equal to margin no override");
        run_epoch(16, 16, 0, 0, 0, "R8 balanced no growth lowers");
        max_warps = 6'd24;
        run_epoch(16, 0, 0, 0, 0, "R5 raise after maximum restored");
        mode_bal = 1'b0;
        run_epoch(16, 16, 0, 16, 0, "R9 issue stalls ignored in congestion mode");

        mode_bal = 1'b1;
        run_epoch(16, 16, 0, 16, 0, "R11 set previous count");
        do_reset();
        run_epoch(16, 16, 0, 6, 0, "R11 previous count cleared by reset");

        mode_bal = 1'b0;
        mc_hi_th = 8'd255;
        run_epoch(300, 300, 0, 0, 0, "R10 count saturates instead of wrapping");
        run_epoch(16, 3, 0, 0, 0, "R10 counts restart each epoch");

        for (int r = 0; r < 60; r++) begin
            mode_bal  = 1'($urandom % 2);
            mc_lo_th  = CW'($urandom % 10);
            mc_hi_th  = CW'(mc_lo_th + ($urandom % 12));
            net_lo_th = CW'($urandom % 10);
            net_hi_th = CW'(net_lo_th + ($urandom % 12));
            k_th      = CW'($urandom % 8);
            if (r % 10 == 0) max_warps = WW'(($urandom % 30) + 1);
            run_epoch(int'($urandom % 40), int'($urandom % 60), int'($urandom % 60),
                      int'($urandom % 100), 1, "R3 R4 R5 R6 R8 random epoch");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule